// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block holds the general registers and the status words of a 32-bit processor core. The datapath always sees sixteen registers, indexed 0 to 15: index 13 is the stack pointer, 14 the link register and 15 the program counter. Some indices are backed by a private copy that depends on the current processor mode. The block only turns an index plus a mode into a physical storage location. Mode sequencing, exception entry, decode and program-counter arithmetic live outside it.

There are two combinational read ports and one write port that commits on the clock edge. A separate pair of access paths reaches the current status word and the saved status word of the active mode. Physical storage is 31 general words plus one current and five saved status words.

The fast-interrupt mode banks indices 8 to 14. The interrupt, supervisor, abort and undefined modes bank only indices 13 and 14. User and system mode share one bank. Each of the five exception modes owns a saved status word.

Top module: `banked_regfile`

## Requirements
- R1: During and straight after reset, every general index reads 0, the current status reads 0x00000013 (the supervisor encoding 5'b10011 in bits 4:0), and every saved status word reads 0.
- R2: Indices 0 to 7 and 15 select the same shared storage in every mode. A value written in one mode reads back unchanged in all other modes.
- R3: In fast-interrupt mode (mode code 5'b10001), indices 8 to 14 select seven private words. Writes there are invisible in other modes, and writes made in other modes to those indices are invisible in fast-interrupt mode.
- R4: Interrupt (5'b10010), supervisor (5'b10011), abort (5'b10111) and undefined (5'b11011) modes each have private words for indices 13 and 14. Their indices 8 to 12 are the shared user words.
- R5: User mode (5'b10000) and system mode (5'b11111) use the same registers. Any mode code not listed here also uses the user registers.
- R6: Each of the five exception modes has its own saved status word. A write in one of these modes does not change the saved word of any other mode.
- R7: In user mode, system mode and unlisted codes, the saved-status read returns the current status word, and a saved-status write is ignored.
- R8: A write becomes visible on the read ports from the cycle after the clock edge that commits it. A read of the same word in the write cycle returns the old value.
- R9: The two read ports are independent. When both carry the same index, they return the same word.
- R10: A write to the current status word is visible from the next cycle and is the same word in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 5 | Current processor mode code |
| rda_idx | input | 4 | Read port A index |
| rda_data | output | 32 | Read port A data |
| rdb_idx | input | 4 | Read port B index |
| rdb_data | output | 32 | Read port B data |
| wr_en | input | 1 | General register write enable |
| wr_idx | input | 4 | Write index |
| wr_data | input | 32 | Write data |
| cst_we | input | 1 | Current status write enable |
| cst_wdata | input | 32 | Current status write data |
| cst_rdata | output | 32 | Current status read data |
| sst_we | input | 1 | Saved status write enable (active mode) |
| sst_wdata | input | 32 | Saved status write data |
| sst_rdata | output | 32 | Saved status read data (active mode) |

## Verification
The main pattern writes a value that encodes both the mode and the index to every index in every mode. It then reads all sixteen indices in each mode plus one unlisted code. Shared words must hold the last writer's value, and banked words must hold their own mode's value. This separates a missing bank, an extra bank and a wrong range boundary at index 8 or 13. Saved-status tests write distinct words per exception mode and then try a write from user mode, which tells isolation apart from aliasing and from a write that should have been dropped. A same-cycle write and read pattern separates old-value reads from bypassed reads.

// File: rtl/rf_pkg.sv
package rf_pkg;

    localparam int IDX_W     = 4;
    localparam int NUM_IDX   = 1 << IDX_W;
    localparam int MODE_W    = 5;
    localparam int NUM_SAVED = 5;
    // shared 16 + fast-interrupt 7 + four modes x 2
    localparam int NUM_PHYS  = NUM_IDX + 7 + 4 * 2;
    localparam int SLOT_W    = $clog2(NUM_PHYS);
    localparam int FAST_BASE = NUM_IDX;
    localparam int DUO_BASE  = FAST_BASE + 7;

    typedef enum logic [MODE_W-1:0] {
        MODE_USER  = 5'b10000,
        MODE_FAST  = 5'b10001,
        MODE_IRQ   = 5'b10010,
        MODE_SUP   = 5'b10011,
        MODE_ABT   = 5'b10111,
        MODE_UND   = 5'b11011,
        MODE_SYS   = 5'b11111
    } mode_e;

    // bank 0 is the user bank; 1..5 own a saved status word
    typedef enum logic [2:0] {
        BANK_USER = 3'd0,
        BANK_FAST = 3'd1,
        BANK_IRQ  = 3'd2,
        BANK_SUP  = 3'd3,
        BANK_ABT  = 3'd4,
        BANK_UND  = 3'd5
    } bank_e;

endpackage

// File: rtl/rf_bank_decode.sv
module rf_bank_decode
    import rf_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    output bank_e             bank,
    output logic              has_saved
);
    always_comb begin
        unique case (mode)
            MODE_FAST: bank = BANK_FAST;
            MODE_IRQ:  bank = BANK_IRQ;
            MODE_SUP:  bank = BANK_SUP;
            MODE_ABT:  bank = BANK_ABT;
            MODE_UND:  bank = BANK_UND;
            default:   bank = BANK_USER;
        endcase
        has_saved = (bank != BANK_USER);
    end
endmodule

// File: rtl/rf_index_map.sv
module rf_index_map
    import rf_pkg::*;
(
    input  bank_e             bank,
    input  logic [IDX_W-1:0]  idx,
    output logic [SLOT_W-1:0] slot
);
    logic hi_range;   // 8..14
    logic duo_range;  // 13..14

    always_comb begin
        hi_range  = (idx >= 4'd8) && (idx <= 4'd14);
        duo_range = (idx >= 4'd13) && (idx <= 4'd14);
        slot      = SLOT_W'(idx);
        if (bank == BANK_FAST && hi_range) begin
            slot = SLOT_W'(FAST_BASE) + SLOT_W'(idx - 4'd8);
        end else if (bank != BANK_USER && bank != BANK_FAST && duo_range) begin
            slot = SLOT_W'(DUO_BASE)
                 + SLOT_W'({2'b00, bank - 3'd2} << 1)
                 + SLOT_W'(idx - 4'd13);
        end
    end
endmodule

// File: rtl/rf_gp_store.sv
module rf_gp_store
    import rf_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [SLOT_W-1:0] wslot,
    input  logic [DW-1:0]     wdata,
    input  logic [SLOT_W-1:0] rslot_a,
    input  logic [SLOT_W-1:0] rslot_b,
    output logic [DW-1:0]     rdata_a,
    output logic [DW-1:0]     rdata_b
);
    logic [DW-1:0] words [NUM_PHYS];

    for (genvar s = 0; s < NUM_PHYS; s++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                words[s] <= '0;
            end else if (we && wslot == SLOT_W'(s)) begin
                words[s] <= wdata;
            end
        end
    end

    always_comb begin
        rdata_a = words[rslot_a];
        rdata_b = words[rslot_b];
    end
endmodule

// File: rtl/rf_status_store.sv
module rf_status_store
    import rf_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  bank_e         bank,
    input  logic          has_saved,
    input  logic          cur_we,
    input  logic [DW-1:0] cur_wdata,
    output logic [DW-1:0] cur_rdata,
    input  logic          sav_we,
    input  logic [DW-1:0] sav_wdata,
    output logic [DW-1:0] sav_rdata
);
    localparam logic [DW-1:0] CUR_RESET = DW'(MODE_SUP);

    logic [DW-1:0] cur_q;
    logic [DW-1:0] saved_q [NUM_SAVED];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= CUR_RESET;
        end else if (cur_we) begin
            cur_q <= cur_wdata;
        end
    end

    for (genvar k = 0; k < NUM_SAVED; k++) begin : g_saved
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                saved_q[k] <= '0;
            end else if (sav_we && has_saved && bank == bank_e'(k + 1)) begin
                saved_q[k] <= sav_wdata;
            end
        end
    end

    always_comb begin
        cur_rdata = cur_q;
        sav_rdata = cur_q;
        if (has_saved) begin
            sav_rdata = saved_q[3'(bank) - 3'd1];
        end
    end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import rf_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_i,
    input  logic [IDX_W-1:0]  rda_idx,
    output logic [DW-1:0]     rda_data,
    input  logic [IDX_W-1:0]  rdb_idx,
    output logic [DW-1:0]     rdb_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DW-1:0]     wr_data,
    input  logic              cst_we,
    input  logic [DW-1:0]     cst_wdata,
    output logic [DW-1:0]     cst_rdata,
    input  logic              sst_we,
    input  logic [DW-1:0]     sst_wdata,
    output logic [DW-1:0]     sst_rdata
);
    bank_e             bank;
    logic              has_saved;
    logic [SLOT_W-1:0] slot_a, slot_b, slot_w;

    rf_bank_decode u_dec (.mode(mode_i), .bank(bank), .has_saved(has_saved));

    rf_index_map u_map_a (.bank(bank), .idx(rda_idx), .slot(slot_a));
    rf_index_map u_map_b (.bank(bank), .idx(rdb_idx), .slot(slot_b));
    rf_index_map u_map_w (.bank(bank), .idx(wr_idx),  .slot(slot_w));

    rf_gp_store #(.DW(DW)) u_gp (
        .clk(clk), .rst_n(rst_n),
        .we(wr_en), .wslot(slot_w), .wdata(wr_data),
        .rslot_a(slot_a), .rslot_b(slot_b),
        .rdata_a(rda_data), .rdata_b(rdb_data)
    );

    rf_status_store #(.DW(DW)) u_st (
        .clk(clk), .rst_n(rst_n),
        .bank(bank), .has_saved(has_saved),
        .cur_we(cst_we), .cur_wdata(cst_wdata), .cur_rdata(cst_rdata),
        .sav_we(sst_we), .sav_wdata(sst_wdata), .sav_rdata(sst_rdata)
    );
endmodule

// File: rtl/banked_regfile_chk.sv
module banked_regfile_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic [4:0]    mode_i,
    input logic [3:0]    rda_idx,
    input logic [DW-1:0] rda_data,
    input logic [3:0]    rdb_idx,
    input logic [DW-1:0] rdb_data,
    input logic          wr_en,
    input logic [3:0]    wr_idx,
    input logic [DW-1:0] wr_data,
    input logic          cst_we,
    input logic [DW-1:0] cst_wdata,
    input logic [DW-1:0] cst_rdata,
    input logic [DW-1:0] sst_rdata
);
    logic exc_mode;
    logic shared_a;
    always_comb begin
        exc_mode = (mode_i == 5'b10001) || (mode_i == 5'b10010) ||
                   (mode_i == 5'b10011) || (mode_i == 5'b10111) ||
                   (mode_i == 5'b11011);
        shared_a = (rda_idx < 4'd8) || (rda_idx == 4'd15);
    end

    // R1
    reset_status_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> cst_rdata == DW'(32'h13));

    // R2
    shared_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr_en) && $stable(rda_idx) && shared_a)
            |-> rda_data == $past(rda_data));

    // R7
    saved_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_mode |-> sst_rdata == cst_rdata);

    // R8
    write_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mode_i != $past(mode_i) || rda_idx != $past(wr_idx)
                   || rda_data == $past(wr_data)));

    // R9
    port_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rda_idx == rdb_idx |-> rda_data == rdb_data);

    // R10
    cur_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cst_we |=> cst_rdata == $past(cst_wdata));
endmodule

bind banked_regfile banked_regfile_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
    .rda_idx(rda_idx), .rda_data(rda_data),
    .rdb_idx(rdb_idx), .rdb_data(rdb_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .cst_we(cst_we), .cst_wdata(cst_wdata), .cst_rdata(cst_rdata),
    .sst_rdata(sst_rdata)
);

// File: tb/banked_regfile_test.sv
module banked_regfile_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  mode_i = 5'b10011;
    logic [3:0]  rda_idx = '0, rdb_idx = '0, wr_idx = '0;
    logic [31:0] rda_data, rdb_data, wr_data = '0;
    logic        wr_en = 1'b0, cst_we = 1'b0, sst_we = 1'b0;
    logic [31:0] cst_wdata = '0, cst_rdata, sst_wdata = '0, sst_rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    localparam logic [4:0] M_USR = 5'b10000, M_FST = 5'b10001, M_IRQ = 5'b10010,
                           M_SUP = 5'b10011, M_ABT = 5'b10111, M_UND = 5'b11011,
                           M_SYS = 5'b11111;

    always #2 clk = ~clk;

    banked_regfile uut (.*);

    function automatic logic [4:0] mode_at(int k);
        case (k)
            0: return M_USR; 1: return M_FST; 2: return M_IRQ; 3: return M_SUP;
            4: return M_ABT; 5: return M_UND; default: return M_SYS;
        endcase
    endfunction

    function automatic logic [31:0] tag(logic [4:0] m, int i);
        return 32'hA000_0000 | (32'(m) << 8) | 32'(i);
    endfunction

    // who wrote last to the word seen at (m, i) after the fill pass (system mode last)
    function automatic logic [4:0] owner(logic [4:0] m, int i);
        if (m == M_FST && i >= 8 && i <= 14) return M_FST;
        if ((i == 13 || i == 14) &&
            (m == M_IRQ || m == M_SUP || m == M_ABT || m == M_UND)) return m;
        return M_SYS;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic write_gp(logic [4:0] m, int i, logic [31:0] v);
        @(negedge clk);
        mode_i = m; wr_idx = 4'(i); wr_data = v; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_gp(logic [4:0] m, int i, output logic [31:0] a, output logic [31:0] b);
        @(negedge clk);
        mode_i = m; rda_idx = 4'(i); rdb_idx = 4'(i);
        #1;
        a = rda_data; b = rdb_data;
    endtask

    task automatic t_reset();
        logic [31:0] a, b;
        for (int i = 0; i < 16; i++) begin
            read_gp(M_SUP, i, a, b);
            check("R1 gp reset", a, 32'h0);
        end
        check("R1 status reset", cst_rdata, 32'h0000_0013);
        for (int k = 1; k < 6; k++) begin
            @(negedge clk); mode_i = mode_at(k); #1;
            check("R1 saved reset", sst_rdata, 32'h0);
        end
    endtask

    task automatic t_fill_and_map();
        logic [31:0] a, b;
        logic [4:0] m;
        for (int k = 0; k < 7; k++)
            for (int i = 0; i < 16; i++) write_gp(mode_at(k), i, tag(mode_at(k), i));
        for (int k = 0; k < 8; k++) begin
            m = (k == 7) ? 5'b00000 : mode_at(k);
            for (int i = 0; i < 16; i++) begin
                read_gp(m, i, a, b);
                if (k == 7) check("R5 unlisted code uses user bank", a, tag(M_SYS, i));
                else if (i < 8 || i == 15) check("R2 shared index", a, tag(M_SYS, i));
                else if (m == M_FST) check("R3 fast bank", a, tag(owner(m, i), i));
                else check("R4/R5 bank map", a, tag(owner(m, i), i));
                check("R9 dual port", b, a);
            end
        end
    endtask

    task automatic t_same_cycle();
        logic [31:0] a, b;
        read_gp(M_ABT, 13, a, b);
        @(negedge clk);
        wr_idx = 4'd13; wr_data = 32'h1357_9BDF; wr_en = 1'b1; #1;
        check("R8 old value in write cycle", rda_data, a);
        @(negedge clk); wr_en = 1'b0; #1;
        check("R8 new value next cycle", rda_data, 32'h1357_9BDF);
        read_gp(M_UND, 13, a, b);
        check("R4 abort copy isolated", a, tag(M_UND, 13));
    endtask

    task automatic t_saved();
        for (int k = 1; k < 6; k++) begin
            @(negedge clk); mode_i = mode_at(k);
            sst_wdata = 32'h5A00_0000 | 32'(k); sst_we = 1'b1;
            @(negedge clk); sst_we = 1'b0;
        end
        @(negedge clk); mode_i = M_USR; sst_wdata = 32'hDEAD_BEEF; sst_we = 1'b1;
        @(negedge clk); sst_we = 1'b0; #1;
        check("R7 user saved reads current", sst_rdata, cst_rdata);
        @(negedge clk); mode_i = M_SYS; #1;
        check("R7 system saved reads current", sst_rdata, cst_rdata);
        for (int k = 1; k < 6; k++) begin
            @(negedge clk); mode_i = mode_at(k); #1;
            check("R6/R7 saved word per mode", sst_rdata, 32'h5A00_0000 | 32'(k));
        end
    endtask

    task automatic t_current();
        @(negedge clk); mode_i = M_SUP; cst_wdata = 32'h1234_5678; cst_we = 1'b1; #1;
        check("R10 status old in write cycle", cst_rdata, 32'h0000_0013);
        @(negedge clk); cst_we = 1'b0; mode_i = M_FST; #1;
        check("R10 status shared", cst_rdata, 32'h1234_5678);
        @(negedge clk); mode_i = M_USR; #1;
        check("R10 status user", cst_rdata, 32'h1234_5678);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R1 status during reset", cst_rdata, 32'h0000_0013);
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_current();
        t_fill_and_map();
        t_same_cycle();
        t_saved();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule